// File: doc/BRIEF.md
# Strobe Watchdog Supervisor

This block checks that software is still running. Software drives a strobe line and must give it a high-to-low transition at least once per watchdog period. If one period passes with no such transition, the block raises a reset request for a fixed number of milliseconds. When that pulse ends, a new period starts. While the strobe stays silent, the block issues one new reset pulse per period.

Time is counted in milliseconds from a one-cycle tick input. The tick comes from a shared timebase elsewhere on the chip. The strobe is asynchronous and passes through a synchronizer chain inside the block. A two-bit code selects one of three period lengths. A hold input clears the watchdog while some other reset source is active.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, and after it is released with no further stimulus, `wdt_rst_o` is 0 and the period counter is empty.
- R2: Only a falling edge of the synchronized strobe restarts the period. A rising edge, a steady high level or a steady low level leaves the running period unchanged.
- R3: With `tsel_i` = 2'd0, `wdt_rst_o` rises on the 150th tick after the last restart and stays low before it.
- R4: With `tsel_i` = 2'd1, the period is 600 ticks.
- R5: With `tsel_i` = 2'd2, the period is 1200 ticks.
- R6: `tsel_i` = 2'd3 gives the same 600-tick period as code 1.
- R7: A reset pulse lasts exactly 250 ticks. `wdt_rst_o` is high from the tick that ends the period until the 250th tick after it.
- R8: If no falling edge arrives, a new period starts when a pulse ends, and a further pulse follows after one full period.
- R9: A falling edge that arrives during a pulse neither shortens the pulse nor moves the next period.
- R10: While `hold_i` is high, `wdt_rst_o` is 0 and the counter is held clear. This also ends a pulse in progress. After `hold_i` falls, a full period starts.
- R11: The strobe passes through a two-flop synchronizer. A low level held for at least 75 ns (15 clock cycles at 200 MHz) is recognized as a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle pulse, once per millisecond |
| strobe_i | input | 1 | Asynchronous software strobe; its falling edges restart the period |
| tsel_i | input | 2 | Period select: 0 = 150 ms, 1 = 600 ms, 2 = 1200 ms, 3 = same as 1 |
| hold_i | input | 1 | Keeps the watchdog clear while another reset source is active |
| wdt_rst_o | output | 1 | Watchdog reset request, active high |

## Verification
All four select codes are run through the same restart, timeout and pulse sequence. Each code is checked one tick before and one tick after its expected timeout, so an off-by-one in the period length shows up. A rising edge placed in the middle of a period tells edge-qualified restarts apart from level-sensitive ones. A falling edge placed inside a pulse shows whether the pulse ignores strobes, and a silent stretch after the pulse separates repeated pulses from a one-shot. Finally, a hold asserted during a period and again during a pulse, and an 18-cycle low strobe, check the clearing path and the synchronizer's minimum recognized width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic {
      WD_WATCH = 1'b0,
      WD_BARK  = 1'b1
   } wd_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic fall_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= strobe_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign fall_o = prev_q & ~sync_q[STAGES-1];

   // R11
   fall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> ($past(strobe_i, STAGES+1) && !$past(strobe_i, STAGES)));

endmodule

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel #(
   parameter int CNT_W     = 11,
   parameter int T0_MS     = 150,
   parameter int T1_MS     = 600,
   parameter int T2_MS     = 1200,
   parameter int CODE3_MAP = 1
) (
   input  logic [1:0]       sel_i,
   output logic [CNT_W-1:0] limit_o
);

   localparam logic [CNT_W-1:0] LIM0 = CNT_W'(T0_MS);
   localparam logic [CNT_W-1:0] LIM1 = CNT_W'(T1_MS);
   localparam logic [CNT_W-1:0] LIM2 = CNT_W'(T2_MS);

   logic [CNT_W-1:0] lim3;

   generate
      if (CODE3_MAP == 0) begin : g_c3_short
         assign lim3 = LIM0;
      end else if (CODE3_MAP == 2) begin : g_c3_long
         assign lim3 = LIM2;
      end else begin : g_c3_mid
         assign lim3 = LIM1;
      end
   endgenerate

   always_comb begin
      unique case (sel_i)
         2'd0:    limit_o = LIM0;
         2'd1:    limit_o = LIM1;
         2'd2:    limit_o = LIM2;
         default: limit_o = lim3;
      endcase
   end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int CNT_W    = 11,
   parameter int PULSE_MS = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             fall_i,
   input  logic             hold_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             bark_o
);

   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_MS - 1);
   localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

   wd_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WD_WATCH;
         cnt_q   <= '0;
      end else if (hold_i) begin
         state_q <= WD_WATCH;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            WD_WATCH: begin
               if (fall_i) begin
                  cnt_q <= '0;
               end else if (tick_i) begin
                  if (cnt_q >= limit_i - ONE) begin
                     state_q <= WD_BARK;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + ONE;
                  end
               end
            end
            WD_BARK: begin
               if (tick_i) begin
                  if (cnt_q >= PULSE_LAST) begin
                     state_q <= WD_WATCH;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + ONE;
                  end
               end
            end
            default: begin
               state_q <= WD_WATCH;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign bark_o = (state_q == WD_BARK);

   // R3
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bark_o) |-> ($past(tick_i) && !$past(hold_i) && !$past(fall_i)));

   // R7
   fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bark_o) |-> ($past(tick_i) || $past(hold_i)));

   // R7
   bark_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bark_o |-> (cnt_q <= PULSE_LAST));

   // R10
   hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_i) |-> (!bark_o && cnt_q == '0));

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
   parameter int T0_MS       = 150,
   parameter int T1_MS       = 600,
   parameter int T2_MS       = 1200,
   parameter int PULSE_MS    = 250,
   parameter int CODE3_MAP   = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms_i,
   input  logic       strobe_i,
   input  logic [1:0] tsel_i,
   input  logic       hold_i,
   output logic       wdt_rst_o
);

   localparam int MAX_MS = wdt_pkg::max_int(wdt_pkg::max_int(T0_MS, T1_MS),
                                            wdt_pkg::max_int(T2_MS, PULSE_MS));
   localparam int CNT_W  = $clog2(MAX_MS + 1);

   generate
      if (T0_MS < 63 || T0_MS > 250) begin : g_bad_t0
         $error("T0_MS out of range 63..250");
      end
      if (T1_MS < 250 || T1_MS > 1000) begin : g_bad_t1
         $error("T1_MS out of range 250..1000");
      end
      if (T2_MS < 500 || T2_MS > 2000) begin : g_bad_t2
         $error("T2_MS out of range 500..2000");
      end
      if (PULSE_MS < 250) begin : g_bad_pulse
         $error("PULSE_MS below 250");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES below 2");
      end
      if (CODE3_MAP < 0 || CODE3_MAP > 2) begin : g_bad_map
         $error("CODE3_MAP must be 0, 1 or 2");
      end
   endgenerate

   logic             fall_w;
   logic [CNT_W-1:0] limit_w;

   wdt_strobe_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_i),
      .fall_o   (fall_w)
   );

   wdt_limit_sel #(
      .CNT_W     (CNT_W),
      .T0_MS     (T0_MS),
      .T1_MS     (T1_MS),
      .T2_MS     (T2_MS),
      .CODE3_MAP (CODE3_MAP)
   ) u_lim (
      .sel_i   (tsel_i),
      .limit_o (limit_w)
   );

   wdt_core #(
      .CNT_W    (CNT_W),
      .PULSE_MS (PULSE_MS)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_ms_i),
      .fall_i  (fall_w),
      .hold_i  (hold_i),
      .limit_i (limit_w),
      .bark_o  (wdt_rst_o)
   );

endmodule

// File: tb/strobe_watchdog_bench.sv
module strobe_watchdog_bench;

   localparam int PULSE   = 250;
   localparam int TDIV    = 6;
   localparam int NVEC    = 4;
   localparam logic [1:0] SEL_TAB [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3};
   localparam int         EXP_TAB [NVEC] = '{150, 600, 1200, 600};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       strobe = 1'b1;
   logic [1:0] tsel = 2'd0;
   logic       hold = 1'b0;
   logic       wdt_rst;
   int         tcnt = 0;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   strobe_watchdog u_strobe_watchdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_ms_i (tick),
      .strobe_i  (strobe),
      .tsel_i    (tsel),
      .hold_i    (hold),
      .wdt_rst_o (wdt_rst)
   );

   always @(negedge clk) begin
      if (!rst_n) begin
         tcnt <= 0;
         tick <= 1'b0;
      end else begin
         tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
         tick <= (tcnt == TDIV-1);
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: wdt_rst_o = %b, expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick_wait(input int n);
      for (int k = 0; k < n; k++) begin
         do @(posedge clk); while (tick !== 1'b1);
      end
      @(negedge clk);
   endtask

   // raise strobe, then drop it right after a tick: ticks counted from here
   task automatic restart();
      strobe = 1'b1;
      tick_wait(1);
      strobe = 1'b0;
   endtask

   function automatic string vec_tag(input int i);
      case (i)
         0:       return "R3";
         1:       return "R4";
         2:       return "R5";
         default: return "R6";
      endcase
   endfunction

   initial begin
      repeat (6) @(negedge clk);
      check("R1", wdt_rst, 1'b0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check("R1", wdt_rst, 1'b0);

      // table walk: every select code, timeout and pulse (R3..R6, R7)
      for (int i = 0; i < NVEC; i++) begin
         tsel = SEL_TAB[i];
         restart();
         tick_wait(EXP_TAB[i] - 1);
         check(vec_tag(i), wdt_rst, 1'b0);
         tick_wait(1);
         check(vec_tag(i), wdt_rst, 1'b1);
         tick_wait(PULSE - 1);
         check("R7", wdt_rst, 1'b1);
         tick_wait(1);
         check("R7", wdt_rst, 1'b0);
      end

      // R2: rising edge mid-period does not restart
      tsel = 2'd0;
      restart();
      tick_wait(100);
      strobe = 1'b1;
      tick_wait(49);
      check("R2", wdt_rst, 1'b0);
      tick_wait(1);
      check("R2", wdt_rst, 1'b1);
      // R9: falling edge inside the pulse is ignored
      tick_wait(100);
      strobe = 1'b0;
      tick_wait(149);
      check("R9", wdt_rst, 1'b1);
      tick_wait(1);
      check("R9", wdt_rst, 1'b0);
      // R8: silence yields another pulse one period later
      tick_wait(149);
      check("R8", wdt_rst, 1'b0);
      tick_wait(1);
      check("R8", wdt_rst, 1'b1);
      tick_wait(PULSE);
      check("R8", wdt_rst, 1'b0);

      // R10: hold during a period
      restart();
      tick_wait(100);
      hold = 1'b1;
      tick_wait(80);
      check("R10", wdt_rst, 1'b0);
      hold = 1'b0;
      tick_wait(149);
      check("R10", wdt_rst, 1'b0);
      tick_wait(1);
      check("R10", wdt_rst, 1'b1);
      // R10: hold ends a pulse in progress
      tick_wait(10);
      hold = 1'b1;
      repeat (2) @(negedge clk);
      check("R10", wdt_rst, 1'b0);
      tick_wait(1);
      hold = 1'b0;
      tick_wait(149);
      check("R10", wdt_rst, 1'b0);
      tick_wait(1);
      check("R10", wdt_rst, 1'b1);
      tick_wait(PULSE);
      check("R10", wdt_rst, 1'b0);

      // R11: an 18-cycle low strobe is recognized as a restart
      restart();
      tick_wait(3);
      strobe = 1'b1;
      tick_wait(150 - 4);
      check("R11", wdt_rst, 1'b0);
      tick_wait(1);
      check("R11", wdt_rst, 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hang, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule